// File: doc/BRIEF.md
# Linear Charger Sequencer

This block is the digital controller of a linear battery charger. It takes its decisions from comparator outputs: the supply window, supply above battery, battery below the pre-charge level, battery at the regulation level, charge current below the full level, supply over-voltage, supply back below the over-voltage release level, and battery below the restart level. From these it walks the charger through six states: idle, pre-charge, fast charge, constant voltage, done and fault. It drives a charger enable and a current target in milliamps. It decodes the configuration codes into the thresholds that the analog side needs: regulation voltage, full-charge current, restart drop and over-voltage limit.

Safety timers run from a prescaled tick. They bound pre-charge to half an hour and fast charge to five, six or seven hours. An optional top-off timer ends charging half an hour after the full-charge point. The tick divider and the number of ticks per half hour are parameters, so a simulation can run the hour-scale limits in a few hundred cycles.

Each state entry and each over-voltage event sets a pending interrupt bit. Each pending bit has its own mask bit. One read strobe clears all pending bits. Configuration fields arrive as plain input ports.

Top module: `chg_seq_top`

## Requirements
- R1: After reset the block is in idle with `chgEnable`=0, `currentMa`=0 and no interrupt pending. The charger is enabled only while all of the following hold: the supply window and supply-above-battery inputs are high, no over-voltage lockout is active, `cfgDisable`=0, and either `cfgForceEn`=1 or `chargerDetected`=1. When the supply window or supply-above-battery input drops, the enable falls on the next clock.
- R2: When charging starts with `batBelowPre`=1, the block enters pre-charge and drives `currentMa`=90.
- R3: Fast charge is entered from pre-charge when `batBelowPre`=0 and `cfgFastEn`=1, from idle directly when the battery is above the pre-charge level, or from done on restart. The current starts at 200 mA, or at the target if the target is lower. It then rises by 50 mA per timer tick until it reaches the target of 200 + 50*`cfgIset` mA. When `cfgIsetHigh`=0 the target is 90 mA.
- R4: While `cfgFastEn`=0, the block stays in pre-charge even with the battery above the pre-charge level.
- R5: In fast charge, `batAtCv`=1 moves the block to constant voltage. `cvMv` is 4000 + 20*`cfgCvSel`, except that code 15 gives 4350.
- R6: In constant voltage, `iBelowFull`=1 behaves in one of two ways. With `cfgAutoStop`=1 the block enters done, keeps charging for TOPOFF_UNITS half-hours of ticks, and then drops the enable while staying in done. With `cfgAutoStop`=0 the block stays in constant voltage and sets the done pending bit once. `ifullMa` is 50 + 10*`cfgIfullSel`.
- R7: In done, `batBelowRestart`=1 returns the block to fast charge with a fresh soft start. `restartMv` decodes codes 0, 1, 2 and 3 to 130, 130, 190 and 240.
- R8: Pre-charge lasting PRE_UNITS half-hours of ticks enters fault and sets status bit 6. Fast charge lasting (10 + 2*`cfgFastTimerSel`) half-hours of ticks enters fault and sets status bit 7. `cfgFastTimerSel`=3 removes the fast-charge limit.
- R9: The fault state, and the timer flags in status bits 7 and 6, clear only on one of two events: a rising edge of (supply window AND supply above battery), or any change of `cfgForceEn`. Either event returns the block to idle.
- R10: `vbusOverVolt`=1 turns the charger off within one clock and sets pending bit 6. Charging stays off until `vbusOverVolt`=0, `vbusBelowOvpHys`=1 and `vbusAboveUvlo`=1 hold together. `ovpMv` is 6000 + 500*`cfgOvpSel`.
- R11: `cfgDisable`=1 forces the charger off and takes priority over `cfgForceEn`.
- R12: Each state entry sets a pending bit: bit 0 idle, 1 pre-charge, 2 fast, 3 constant voltage, 4 done, 5 fault. Bit 6 marks over-voltage. `irq` is the OR of the pending bits whose `irqMask` bit is 0. A pulse on `irqReadClr` clears all pending bits, and a bit set in that same cycle survives.
- R13: `status[5:0]` is one-hot on the current state, in the same bit order as the pending bits. `status[6]` is the pre-charge timeout flag and `status[7]` is the fast-charge timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vbusWindowOk | input | 1 | Supply inside the charging window |
| vbusAboveBat | input | 1 | Supply exceeds battery by the headroom margin |
| vbusAboveUvlo | input | 1 | Supply above under-voltage lockout |
| vbusOverVolt | input | 1 | Supply above over-voltage limit |
| vbusBelowOvpHys | input | 1 | Supply below over-voltage limit minus hysteresis |
| batBelowPre | input | 1 | Battery below pre-charge level |
| batAtCv | input | 1 | Battery at regulation voltage |
| iBelowFull | input | 1 | Charge current below full-charge level |
| batBelowRestart | input | 1 | Battery dropped by the restart amount |
| chargerDetected | input | 1 | Dedicated, downstream-charging or car-kit source present |
| cfgDisable | input | 1 | Force charger off |
| cfgForceEn | input | 1 | Enable regardless of source type |
| cfgFastEn | input | 1 | Allow fast charge |
| cfgFastTimerSel | input | 2 | Fast-charge limit: 5/6/7 h, 3 = none |
| cfgAutoStop | input | 1 | Enable top-off shutoff |
| cfgIsetHigh | input | 1 | 0 = 90 mA fast current |
| cfgIset | input | 4 | Fast current code |
| cfgCvSel | input | 4 | Regulation voltage code |
| cfgIfullSel | input | 4 | Full-charge current code |
| cfgRestartSel | input | 2 | Restart drop code |
| cfgOvpSel | input | 2 | Over-voltage limit code |
| irqMask | input | 7 | 1 masks the matching pending bit |
| irqReadClr | input | 1 | Clear all pending bits |
| chgEnable | output | 1 | Charger enable |
| currentMa | output | 10 | Current target in mA |
| cvMv | output | 13 | Regulation voltage in mV |
| ifullMa | output | 8 | Full-charge current in mA |
| restartMv | output | 8 | Restart drop in mV |
| ovpMv | output | 13 | Over-voltage limit in mV |
| irqPending | output | 7 | Pending interrupt bits |
| irq | output | 1 | Unmasked interrupt request |
| status | output | 8 | State one-hot plus timeout flags |

## Verification
The assertions guard these cycle-level rules on every cycle:
- the enable falls one clock after the supply leaves, after over-voltage, or after a forced disable;
- the current stays at 90 mA through pre-charge;
- the soft start never steps by more than one increment;
- a pre-charge timeout always lands in fault;
- a read strobe with no new event empties the pending bits.

Only the bench scenarios can show the longer behaviour:
- the full 200-to-950 mA ramp order, which the scoreboard follows;
- the half-hour and hour-scale timeouts and the choice among them;
- the top-off shutoff and the restart from done;
- the over-voltage release once the hysteresis is crossed;
- the fault clearing only on re-attach or on a change of the force-enable bit.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_FAST  = 3'd2,
    ST_CV    = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } chgState_t;

  localparam int NUM_STATES = 6;
  localparam int IRQ_W      = NUM_STATES + 1;

  localparam int IDX_IDLE  = 0;
  localparam int IDX_PRE   = 1;
  localparam int IDX_FAST  = 2;
  localparam int IDX_CV    = 3;
  localparam int IDX_DONE  = 4;
  localparam int IDX_FAULT = 5;
  localparam int IDX_OVP   = 6;

  // Strobes from the sequencer to the datapath, aligned with the new state
  typedef struct packed {
    logic [NUM_STATES-1:0] enterOh;
    logic                  doneEvt;
    logic                  ovpEvt;
    logic                  pteSet;
    logic                  fteSet;
    logic                  flagClr;
    logic                  tick;
  } ctrlStb_t;

endpackage

// File: rtl/chg_ctrl.sv
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int TICK_DIV        = 1000,
  parameter int HALF_HOUR_TICKS = 1800,
  parameter int PRE_UNITS       = 1,
  parameter int TOPOFF_UNITS    = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vbusWindowOk,
  input  logic       vbusAboveBat,
  input  logic       vbusAboveUvlo,
  input  logic       vbusOverVolt,
  input  logic       vbusBelowOvpHys,
  input  logic       batBelowPre,
  input  logic       batAtCv,
  input  logic       iBelowFull,
  input  logic       batBelowRestart,
  input  logic       chargerDetected,
  input  logic       cfgDisable,
  input  logic       cfgForceEn,
  input  logic       cfgFastEn,
  input  logic [1:0] cfgFastTimerSel,
  input  logic       cfgAutoStop,
  output chgState_t  state,
  output logic       chgEn,
  output ctrlStb_t   stb
);

  localparam int FAST_BASE_UNITS = 10;
  localparam int FAST_STEP_UNITS = 2;
  localparam int FAST_MAX_UNITS  = FAST_BASE_UNITS + 3 * FAST_STEP_UNITS;
  localparam int MAX_UNITS = (FAST_MAX_UNITS > PRE_UNITS) ?
                             ((FAST_MAX_UNITS > TOPOFF_UNITS) ? FAST_MAX_UNITS : TOPOFF_UNITS) :
                             ((PRE_UNITS > TOPOFF_UNITS) ? PRE_UNITS : TOPOFF_UNITS);
  localparam int TMR_W   = $clog2(MAX_UNITS * HALF_HOUR_TICKS + 1);
  localparam int PRESC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TMR_W-1:0] LIM_PRE    = TMR_W'(PRE_UNITS * HALF_HOUR_TICKS);
  localparam logic [TMR_W-1:0] LIM_TOPOFF = TMR_W'(TOPOFF_UNITS * HALF_HOUR_TICKS);

  logic [PRESC_W-1:0] presc;
  logic               tick;
  logic [TMR_W-1:0]   tmr;
  logic [TMR_W-1:0]   limit;
  logic               timed;
  logic               expire;
  logic               ovpLock;
  logic               presentNow;
  logic               presentPrev;
  logic               forceEnPrev;
  logic               clearEvt;
  logic               chargeOk;
  logic               topoffOff;
  logic               cvDoneSent;
  chgState_t          nxt;
  ctrlStb_t           stbNxt;

  assign tick       = (presc == PRESC_W'(TICK_DIV - 1));
  assign presentNow = vbusWindowOk && vbusAboveBat;
  assign clearEvt   = (presentNow && !presentPrev) || (cfgForceEn != forceEnPrev);
  assign chargeOk   = presentNow && !ovpLock && !vbusOverVolt && !cfgDisable &&
                      (cfgForceEn || chargerDetected);

  // Safety timer window selection
  always_comb begin
    timed = 1'b0;
    limit = LIM_PRE;
    case (state)
      ST_PRE: begin
        timed = 1'b1;
        limit = LIM_PRE;
      end
      ST_FAST: begin
        timed = (cfgFastTimerSel != 2'd3);
        limit = TMR_W'((FAST_BASE_UNITS + FAST_STEP_UNITS * int'(cfgFastTimerSel)) * HALF_HOUR_TICKS);
      end
      ST_DONE: begin
        timed = cfgAutoStop && !topoffOff;
        limit = LIM_TOPOFF;
      end
      default: begin
        timed = 1'b0;
        limit = LIM_PRE;
      end
    endcase
  end

  assign expire = timed && tick && (tmr == limit - TMR_W'(1));

  // Next state
  always_comb begin
    nxt            = state;
    stbNxt         = '0;
    stbNxt.tick    = tick;
    stbNxt.ovpEvt  = vbusOverVolt && !ovpLock;
    case (state)
      ST_IDLE: begin
        if (chargeOk) nxt = (batBelowPre || !cfgFastEn) ? ST_PRE : ST_FAST;
      end
      ST_PRE: begin
        if (!chargeOk) nxt = ST_IDLE;
        else if (expire) begin
          nxt           = ST_FAULT;
          stbNxt.pteSet = 1'b1;
        end else if (!batBelowPre && cfgFastEn) nxt = ST_FAST;
      end
      ST_FAST: begin
        if (!chargeOk) nxt = ST_IDLE;
        else if (expire) begin
          nxt           = ST_FAULT;
          stbNxt.fteSet = 1'b1;
        end else if (batAtCv) nxt = ST_CV;
      end
      ST_CV: begin
        if (!chargeOk) nxt = ST_IDLE;
        else if (iBelowFull) begin
          if (cfgAutoStop) nxt = ST_DONE;
          else if (!cvDoneSent) stbNxt.doneEvt = 1'b1;
        end
      end
      ST_DONE: begin
        if (!chargeOk) nxt = ST_IDLE;
        else if (batBelowRestart) nxt = ST_FAST;
      end
      ST_FAULT: begin
        if (clearEvt) begin
          nxt            = ST_IDLE;
          stbNxt.flagClr = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    for (int i = 0; i < NUM_STATES; i++) begin
      stbNxt.enterOh[i] = (nxt != state) && (nxt == chgState_t'(3'(i)));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc       <= '0;
      state       <= ST_IDLE;
      tmr         <= '0;
      ovpLock     <= 1'b0;
      presentPrev <= 1'b0;
      forceEnPrev <= 1'b0;
      topoffOff   <= 1'b0;
      cvDoneSent  <= 1'b0;
      stb         <= '0;
    end else begin
      presc       <= tick ? '0 : presc + PRESC_W'(1);
      state       <= nxt;
      presentPrev <= presentNow;
      forceEnPrev <= cfgForceEn;
      stb         <= stbNxt;
      if (vbusOverVolt) ovpLock <= 1'b1;
      else if (vbusBelowOvpHys && vbusAboveUvlo) ovpLock <= 1'b0;
      if (nxt != state || !timed) tmr <= '0;
      else if (tick) tmr <= tmr + TMR_W'(1);
      if (nxt != state) topoffOff <= 1'b0;
      else if (state == ST_DONE && expire) topoffOff <= 1'b1;
      if (nxt != state) cvDoneSent <= 1'b0;
      else if (stbNxt.doneEvt) cvDoneSent <= 1'b1;
    end
  end

  assign chgEn = ((state == ST_PRE) || (state == ST_FAST) || (state == ST_CV) ||
                  (state == ST_DONE)) && !(state == ST_DONE && topoffOff);

  AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (!rstN) !presentNow |=> !chgEn); // R1
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN) cfgDisable |=> !chgEn); // R11
  AST_OVP_OFF: assert property (@(posedge clk) disable iff (!rstN) vbusOverVolt |=> !chgEn); // R10
  AST_PRE_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN) (state == ST_PRE && chargeOk && expire) |=> state == ST_FAULT); // R8
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rstN) (state == ST_FAULT && !clearEvt) |=> state == ST_FAULT); // R9

endmodule

// File: rtl/chg_dp.sv
module chg_dp
  import chg_pkg::*;
#(
  parameter int PRE_MA       = 90,
  parameter int FAST_BASE_MA = 200,
  parameter int FAST_STEP_MA = 50,
  parameter int RAMP_STEP_MA = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  chgState_t        state,
  input  logic             chgEn,
  input  ctrlStb_t         stb,
  input  logic             cfgIsetHigh,
  input  logic [3:0]       cfgIset,
  input  logic [3:0]       cfgCvSel,
  input  logic [3:0]       cfgIfullSel,
  input  logic [1:0]       cfgRestartSel,
  input  logic [1:0]       cfgOvpSel,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic             irqReadClr,
  output logic [9:0]       currentMa,
  output logic [12:0]      cvMv,
  output logic [7:0]       ifullMa,
  output logic [7:0]       restartMv,
  output logic [12:0]      ovpMv,
  output logic [IRQ_W-1:0] irqPending,
  output logic             irq,
  output logic [7:0]       status
);

  logic [9:0]            target;
  logic [9:0]            curReg;
  logic [10:0]           rampSum;
  logic [IRQ_W-1:0]      setVec;
  logic [NUM_STATES-1:0] stateOh;
  logic                  pteFlag;
  logic                  fteFlag;

  assign target  = cfgIsetHigh ? 10'(FAST_BASE_MA + FAST_STEP_MA * int'(cfgIset)) : 10'(PRE_MA);
  assign rampSum = {1'b0, curReg} + 11'(RAMP_STEP_MA);

  // Current target with soft start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curReg <= '0;
    end else if (!chgEn) begin
      curReg <= '0;
    end else if (stb.enterOh[IDX_FAST]) begin
      curReg <= (target < 10'(FAST_BASE_MA)) ? target : 10'(FAST_BASE_MA);
    end else begin
      case (state)
        ST_PRE:  curReg <= 10'(PRE_MA);
        ST_FAST: begin
          if (curReg > target) curReg <= target;
          else if (stb.tick && curReg < target)
            curReg <= (rampSum > {1'b0, target}) ? target : rampSum[9:0];
        end
        ST_CV, ST_DONE: if (curReg > target) curReg <= target;
        default: curReg <= '0;
      endcase
    end
  end

  assign currentMa = chgEn ? curReg : '0;

  // Threshold decodes
  assign cvMv    = (cfgCvSel == 4'hF) ? 13'd4350 : 13'(4000 + 20 * int'(cfgCvSel));
  assign ifullMa = 8'(50 + 10 * int'(cfgIfullSel));
  assign ovpMv   = 13'(6000 + 500 * int'(cfgOvpSel));
  always_comb begin
    case (cfgRestartSel)
      2'd2:    restartMv = 8'd190;
      2'd3:    restartMv = 8'd240;
      default: restartMv = 8'd130;
    endcase
  end

  // Pending interrupts, read-to-clear, new events win
  always_comb begin
    setVec            = {stb.ovpEvt, stb.enterOh};
    setVec[IDX_DONE]  = stb.enterOh[IDX_DONE] | stb.doneEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= '0;
      pteFlag    <= 1'b0;
      fteFlag    <= 1'b0;
    end else begin
      irqPending <= (irqReadClr ? '0 : irqPending) | setVec;
      if (stb.flagClr) begin
        pteFlag <= 1'b0;
        fteFlag <= 1'b0;
      end else begin
        if (stb.pteSet) pteFlag <= 1'b1;
        if (stb.fteSet) fteFlag <= 1'b1;
      end
    end
  end

  assign irq = |(irqPending & ~irqMask);

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_stateOh
    assign stateOh[i] = (state == chgState_t'(3'(i)));
  end

  assign status = {fteFlag, pteFlag, stateOh};

  AST_PRE_CURRENT: assert property (@(posedge clk) disable iff (!rstN) (state == ST_PRE && $past(state) == ST_PRE) |-> currentMa == 10'(PRE_MA)); // R2
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rstN) (state == ST_FAST && $past(state) == ST_FAST && !$past(stb.enterOh[IDX_FAST])) |-> {1'b0, curReg} <= {1'b0, $past(curReg)} + 11'(RAMP_STEP_MA)); // R3
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN) (irqReadClr && setVec == '0) |=> irqPending == '0); // R12

endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_pkg::*;
#(
  parameter int TICK_DIV        = 1000,
  parameter int HALF_HOUR_TICKS = 1800,
  parameter int PRE_UNITS       = 1,
  parameter int TOPOFF_UNITS    = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        vbusWindowOk,
  input  logic        vbusAboveBat,
  input  logic        vbusAboveUvlo,
  input  logic        vbusOverVolt,
  input  logic        vbusBelowOvpHys,
  input  logic        batBelowPre,
  input  logic        batAtCv,
  input  logic        iBelowFull,
  input  logic        batBelowRestart,
  input  logic        chargerDetected,
  input  logic        cfgDisable,
  input  logic        cfgForceEn,
  input  logic        cfgFastEn,
  input  logic [1:0]  cfgFastTimerSel,
  input  logic        cfgAutoStop,
  input  logic        cfgIsetHigh,
  input  logic [3:0]  cfgIset,
  input  logic [3:0]  cfgCvSel,
  input  logic [3:0]  cfgIfullSel,
  input  logic [1:0]  cfgRestartSel,
  input  logic [1:0]  cfgOvpSel,
  input  logic [6:0]  irqMask,
  input  logic        irqReadClr,
  output logic        chgEnable,
  output logic [9:0]  currentMa,
  output logic [12:0] cvMv,
  output logic [7:0]  ifullMa,
  output logic [7:0]  restartMv,
  output logic [12:0] ovpMv,
  output logic [6:0]  irqPending,
  output logic        irq,
  output logic [7:0]  status
);

  chgState_t state;
  ctrlStb_t  stb;

  chg_ctrl #(
    .TICK_DIV(TICK_DIV), .HALF_HOUR_TICKS(HALF_HOUR_TICKS),
    .PRE_UNITS(PRE_UNITS), .TOPOFF_UNITS(TOPOFF_UNITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .vbusWindowOk(vbusWindowOk), .vbusAboveBat(vbusAboveBat),
    .vbusAboveUvlo(vbusAboveUvlo), .vbusOverVolt(vbusOverVolt),
    .vbusBelowOvpHys(vbusBelowOvpHys), .batBelowPre(batBelowPre),
    .batAtCv(batAtCv), .iBelowFull(iBelowFull),
    .batBelowRestart(batBelowRestart), .chargerDetected(chargerDetected),
    .cfgDisable(cfgDisable), .cfgForceEn(cfgForceEn), .cfgFastEn(cfgFastEn),
    .cfgFastTimerSel(cfgFastTimerSel), .cfgAutoStop(cfgAutoStop),
    .state(state), .chgEn(chgEnable), .stb(stb)
  );

  chg_dp dp_i (
    .clk(clk), .rstN(rstN), .state(state), .chgEn(chgEnable), .stb(stb),
    .cfgIsetHigh(cfgIsetHigh), .cfgIset(cfgIset), .cfgCvSel(cfgCvSel),
    .cfgIfullSel(cfgIfullSel), .cfgRestartSel(cfgRestartSel),
    .cfgOvpSel(cfgOvpSel), .irqMask(irqMask), .irqReadClr(irqReadClr),
    .currentMa(currentMa), .cvMv(cvMv), .ifullMa(ifullMa),
    .restartMv(restartMv), .ovpMv(ovpMv), .irqPending(irqPending),
    .irq(irq), .status(status)
  );

endmodule

// File: tb/chg_seq_top_tb_top.sv
module chg_seq_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vbusWindowOk = 0, vbusAboveBat = 0, vbusAboveUvlo = 1, vbusOverVolt = 0;
  logic vbusBelowOvpHys = 1, batBelowPre = 0, batAtCv = 0, iBelowFull = 0;
  logic batBelowRestart = 0, chargerDetected = 0, cfgDisable = 0, cfgForceEn = 1;
  logic cfgFastEn = 1, cfgAutoStop = 1, cfgIsetHigh = 1;
  logic [1:0] cfgFastTimerSel = 0, cfgRestartSel = 0, cfgOvpSel = 3;
  logic [3:0] cfgIset = 15, cfgCvSel = 10, cfgIfullSel = 1;
  logic [6:0] irqMask = 0;
  logic irqReadClr = 0;
  logic chgEnable, irq;
  logic [9:0] currentMa;
  logic [12:0] cvMv, ovpMv;
  logic [7:0] ifullMa, restartMv, status;
  logic [6:0] irqPending;

  int checks = 0;
  int fails = 0;
  int expQ[$];
  bit sbOn = 0;
  logic [9:0] lastCur = '0;

  always #2 clk = ~clk;

  chg_seq_top #(.TICK_DIV(2), .HALF_HOUR_TICKS(5)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushRamp();
    for (int v = 200; v <= 950; v += 50) expQ.push_back(v);
  endtask

  task automatic clearIrq();
    irqReadClr = 1;
    waitN(1);
    irqReadClr = 0;
    waitN(1);
  endtask

  // Scoreboard monitor: every change of the current target is compared
  always @(negedge clk) begin
    if (sbOn && currentMa != lastCur) begin
      if (expQ.size() == 0) chk("R3 unexpected current step", int'(currentMa), -1);
      else chk("R3 ramp step", int'(currentMa), expQ.pop_front());
    end
    lastCur = currentMa;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitN(4);
    rstN = 1;
    waitN(2);
    // R1 reset state, R13 status
    chk("R1 reset enable", chgEnable, 0);
    chk("R1 reset current", currentMa, 0);
    chk("R1 reset pending", irqPending, 0);
    chk("R13 reset status", status, 8'h01);
    // decodes
    chk("R5 cv 10", cvMv, 4200);
    cfgCvSel = 15; waitN(1); chk("R5 cv 15", cvMv, 4350);
    cfgCvSel = 0;  waitN(1); chk("R5 cv 0", cvMv, 4000);
    chk("R6 ifull 1", ifullMa, 60);
    cfgIfullSel = 15; waitN(1); chk("R6 ifull 15", ifullMa, 200);
    chk("R7 restart 0", restartMv, 130);
    cfgRestartSel = 1; waitN(1); chk("R7 restart 1", restartMv, 130);
    cfgRestartSel = 2; waitN(1); chk("R7 restart 2", restartMv, 190);
    cfgRestartSel = 3; waitN(1); chk("R7 restart 3", restartMv, 240);
    chk("R10 ovp 3", ovpMv, 7500);
    cfgOvpSel = 0; waitN(1); chk("R10 ovp 0", ovpMv, 6000);

    // R11: without forced enable, needs a detected source
    cfgForceEn = 0; vbusWindowOk = 1; vbusAboveBat = 1; batBelowPre = 1;
    waitN(5);
    chk("R11 no source no charge", chgEnable, 0);
    chk("R11 idle status", status, 8'h01);
    chargerDetected = 1;
    waitN(3);
    chk("R2 pre status", status, 8'h02);
    chk("R2 pre enable", chgEnable, 1);
    chk("R2 pre current", currentMa, 90);
    // R8 pre-charge timeout
    waitN(15);
    chk("R8 pte fault status", status, 8'h60);
    chk("R8 fault enable off", chgEnable, 0);
    chk("R12 pending pre+fault", irqPending, 7'h22);
    chk("R12 irq unmasked", irq, 1);
    // R9 fault holds until a clearing event
    batBelowPre = 0;
    waitN(10);
    chk("R9 fault held", status, 8'h60);
    // R9 clear by force-enable change, R3 ramp on fast entry
    pushRamp();
    sbOn = 1;
    cfgForceEn = 1;
    waitN(40);
    chk("R3 ramp complete", expQ.size(), 0);
    sbOn = 0;
    chk("R9 cleared into fast", status, 8'h04);
    chk("R3 final current", currentMa, 950);
    chk("R12 pending idle+fast", irqPending, 7'h27);
    irqMask = 7'h7F; waitN(1);
    chk("R12 masked irq", irq, 0);
    irqMask = 0;
    clearIrq();
    chk("R12 read clear", irqPending, 0);
    chk("R12 irq low after clear", irq, 0);

    // R5 constant voltage
    batAtCv = 1; waitN(3);
    chk("R5 cv status", status, 8'h08);
    chk("R5 cv current held", currentMa, 950);
    // R6 no autostop
    cfgAutoStop = 0;
    clearIrq();
    iBelowFull = 1; waitN(4);
    chk("R6 stay cv", status, 8'h08);
    chk("R6 done pending", irqPending, 7'h10);
    chk("R6 still charging", chgEnable, 1);
    clearIrq(); waitN(4);
    chk("R6 done raised once", irqPending, 0);
    // R6 autostop
    cfgAutoStop = 1; waitN(3);
    chk("R6 done status", status, 8'h10);
    chk("R6 topoff charging", chgEnable, 1);
    chk("R12 done pending", irqPending, 7'h10);
    waitN(15);
    chk("R6 topoff shutoff", chgEnable, 0);
    chk("R6 shutoff current", currentMa, 0);
    chk("R6 remains done", status, 8'h10);
    // R7 restart
    batAtCv = 0; iBelowFull = 0;
    pushRamp();
    sbOn = 1;
    batBelowRestart = 1; waitN(3);
    batBelowRestart = 0;
    chk("R7 restart into fast", status, 8'h04);
    waitN(40);
    chk("R7 restart ramp complete", expQ.size(), 0);
    sbOn = 0;
    // R3 low current select
    cfgIsetHigh = 0; waitN(3);
    chk("R3 iset low current", currentMa, 90);
    cfgIsetHigh = 1;

    // R1 supply loss
    vbusWindowOk = 0; waitN(3);
    chk("R1 supply loss enable", chgEnable, 0);
    chk("R1 supply loss idle", status, 8'h01);
    // R8 fast timeout (sel 0: 50 ticks)
    vbusWindowOk = 1;
    waitN(90);
    chk("R8 fast before limit", status, 8'h04);
    waitN(25);
    chk("R8 fte fault status", status, 8'hA0);
    // R9 clear by re-attach, R8 no limit with sel 3
    vbusWindowOk = 0; waitN(3);
    chk("R9 fault survives removal", status, 8'hA0);
    cfgFastTimerSel = 3;
    vbusWindowOk = 1; waitN(200);
    chk("R8 no fast limit", status, 8'h04);

    // R4 fast enable held low
    vbusWindowOk = 0; waitN(3);
    cfgFastEn = 0; vbusWindowOk = 1; waitN(4);
    chk("R4 held in pre", status, 8'h02);
    cfgFastEn = 1; waitN(3);
    chk("R4 released to fast", status, 8'h04);

    // R10 over-voltage lockout with hysteresis
    clearIrq();
    vbusOverVolt = 1; vbusBelowOvpHys = 0; waitN(4);
    chk("R10 ovp enable off", chgEnable, 0);
    chk("R10 ovp pending", irqPending, 7'h41);
    vbusOverVolt = 0; waitN(5);
    chk("R10 held in hysteresis", chgEnable, 0);
    vbusBelowOvpHys = 1; waitN(4);
    chk("R10 resumed", status, 8'h04);

    // R11 disable wins over forced enable
    cfgDisable = 1; waitN(3);
    chk("R11 disable off", chgEnable, 0);
    chk("R11 disable idle", status, 8'h01);
    cfgDisable = 0; waitN(3);
    chk("R11 disable released", chgEnable, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule